// File: doc/BRIEF.md
# Sequential-Address Flash Burst Program Sequencer

This block sits on the host side of a serial flash link. It writes a run of consecutive bytes into the flash using the device's self-incrementing program mode. A client starts a run with a start address and a byte count on a valid/ready command port. It then supplies the payload bytes on a second valid/ready stream. The sequencer turns the run into chip-select frames for a byte-level SPI engine. The engine shifts one byte per request and returns the byte it received.

The sequence has a fixed shape. First comes a write-enable frame. The first program frame carries the opcode, the full address and the first byte. Each later byte goes out in a short frame that holds only the opcode and the data. After every byte frame, chip select is released and the status register is polled in a fresh frame until the busy bit reads clear. The run closes with a write-disable frame and a final status poll. Only after that is done pulsed.

Runs that would pass a configured top address are shortened at that address and flagged. A status poll that stays busy for too many reads ends the run with a timeout flag. Chip select is always released for a programmable minimum number of clocks between frames.

Top module: `flash_burst_prog`

## Requirements
- R1: After reset, spi_cs is low, spi_start, done, err_range and err_timeout are low, and cmd_ready is high.
- R2: A run with at least one byte to write opens with a single-byte frame carrying 0x06, with spi_last high.
- R3: The first program frame carries 0xAF, then the start address as three bytes from the most significant downwards, then the first payload byte. spi_last is high only on the payload byte. A payload byte is taken from the stream in the same cycle its spi_start is issued.
- R4: Every later payload byte goes out in its own two-byte frame: 0xAF, then the payload byte with spi_last high.
- R5: After each program frame, a status frame sends 0x05 and then 0x00 dummy bytes. The frame is released on the first dummy reply whose bit 0 is 0. The reply to the 0x05 byte itself is ignored, and spi_last stays low throughout the frame.
- R6: After the status poll that follows the last payload byte, a single-byte frame carries 0x04 with spi_last high. A final status poll follows it. Then done pulses for exactly one cycle with spi_cs low.
- R7: Between any two frames, spi_cs stays low for at least GAP_CLKS clock cycles.
- R8: If the run would pass TOP_ADDR, only the bytes up to and including TOP_ADDR are written, and err_range is high with done. If the start address is above TOP_ADDR and the length is nonzero, no frame is sent and done comes with err_range high.
- R9: If POLL_MAX consecutive dummy replies in one status frame all have bit 0 set, the frame is released, no further frame is sent, and done comes with err_timeout high. A later command runs normally.
- R10: spi_start is issued only while spi_cs is high and no byte is outstanding. spi_cs stays high from each spi_start until the matching spi_done.
- R11: A command is accepted only while idle. cmd_valid while a run is active has no effect on the frames sent. A zero-length run produces no frame and finishes with both error flags low.
- R12: spi_last marks the final byte of the fixed-length frames (enable, program, disable) and is never high inside a status frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Run request valid |
| cmd_ready | output | 1 | Sequencer idle, request accepted on valid |
| cmd_addr | input | ADDR_W | Start address of the run |
| cmd_len | input | LEN_W | Number of bytes to program |
| wr_valid | input | 1 | Payload byte valid |
| wr_ready | output | 1 | Payload byte consumed this cycle |
| wr_data | input | 8 | Payload byte |
| spi_cs | output | 1 | Chip select, high means the flash is selected |
| spi_start | output | 1 | Request one byte transfer from the engine |
| spi_byte | output | 8 | Byte to shift out with spi_start |
| spi_last | output | 1 | Final byte of a fixed-length frame |
| spi_done | input | 1 | Engine finished the outstanding byte |
| spi_rx | input | 8 | Byte received during that transfer |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_range | output | 1 | Run shortened or rejected at the top address |
| err_timeout | output | 1 | Status poll limit exceeded |

## Verification
The bound checker watches the link rules on every clock. These are: one outstanding byte at a time, chip select held across each transfer, the minimum deselect gap, payload hand-off coinciding with a final-byte request, a single-cycle done with the link released, and error flags that rise only with done. The byte order inside frames, the address serialisation, the choice between program and disable frames, poll termination on bit 0, truncation arithmetic and timeout recovery depend on the run's history. Only the bench's scenarios can show them, by comparing each requested byte against a model-built expected stream while a responder plays the flash status replies.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_ISSUE,
      ST_WAIT,
      ST_FINISH
   } fbw_state_e;

   typedef enum logic [2:0] {
      FR_WREN,
      FR_FIRST,
      FR_NEXT,
      FR_POLL,
      FR_WRDI
   } fbw_frame_e;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_PROG  = 8'hAF;
   localparam logic [7:0] OP_STAT  = 8'h05;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] BYTE_PAD = 8'h00;

endpackage

// File: rtl/fbw_gap_timer.sv
module fbw_gap_timer #(
   parameter int GAP_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic clear
);
   localparam int CW = (GAP_CLKS > 0) ? $clog2(GAP_CLKS + 1) : 1;

   generate
      if (GAP_CLKS == 0) begin : g_nogap
         logic gap_unused;
         assign gap_unused = load ^ clk ^ rst_n;
         assign clear = 1'b1;
      end else begin : g_gap
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (load) begin
               cnt <= CW'(GAP_CLKS);
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end
         assign clear = (cnt == '0) && !load;
      end
   endgenerate

endmodule

// File: rtl/fbw_poll_limit.sv
module fbw_poll_limit #(
   parameter int POLL_MAX = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic at_limit
);
   localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

   generate
      if (POLL_MAX == 0) begin : g_unlimited
         logic lim_unused;
         assign lim_unused = clr ^ bump ^ clk ^ rst_n;
         assign at_limit = 1'b0;
      end else begin : g_limited
         logic [PW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clr) begin
               cnt <= '0;
            end else if (bump) begin
               cnt <= cnt + 1'b1;
            end
         end
         assign at_limit = (cnt == PW'(POLL_MAX - 1));
      end
   endgenerate

endmodule

// File: rtl/fbw_run_tracker.sv
module fbw_run_tracker #(
   parameter int                ADDR_W   = 24,
   parameter int                LEN_W    = 16,
   parameter logic [ADDR_W-1:0] TOP_ADDR = 'h07FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [LEN_W-1:0]  len_in,
   input  logic              take,
   output logic [ADDR_W-1:0] start_addr,
   output logic              rem_zero,
   output logic              trunc
);
   localparam int WW = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

   logic [WW-1:0]     avail_w;
   logic [WW-1:0]     len_w;
   logic              trunc_c;
   logic [LEN_W-1:0]  rem;

   always_comb begin
      len_w = WW'(len_in);
      if (addr_in > TOP_ADDR) begin
         avail_w = '0;
      end else begin
         avail_w = WW'(TOP_ADDR) - WW'(addr_in) + WW'(1);
      end
      trunc_c = (len_w > avail_w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem        <= '0;
         trunc      <= 1'b0;
         start_addr <= '0;
      end else if (load) begin
         rem        <= trunc_c ? avail_w[LEN_W-1:0] : len_in;
         trunc      <= trunc_c;
         start_addr <= addr_in;
      end else if (take && (rem != '0)) begin
         rem <= rem - 1'b1;
      end
   end

   assign rem_zero = (rem == '0);

endmodule

// File: rtl/flash_burst_prog.sv
module flash_burst_prog
   import fbw_pkg::*;
#(
   parameter int                ADDR_W   = 24,
   parameter int                LEN_W    = 16,
   parameter logic [ADDR_W-1:0] TOP_ADDR = 'h07FFFF,
   parameter int                GAP_CLKS = 4,
   parameter int                POLL_MAX = 64,
   parameter int                BUSY_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [7:0]        wr_data,
   output logic              spi_cs,
   output logic              spi_start,
   output logic [7:0]        spi_byte,
   output logic              spi_last,
   input  logic              spi_done,
   input  logic [7:0]        spi_rx,
   output logic              done,
   output logic              err_range,
   output logic              err_timeout
);
   localparam int AB       = ADDR_W / 8;
   localparam int DATA_IDX = AB + 1;
   localparam int IW       = $clog2(DATA_IDX + 1);

   initial begin : p_param_chk
      if ((ADDR_W % 8) != 0 || ADDR_W < 8)
         $fatal(1, "ADDR_W must be a nonzero multiple of 8");
      if (LEN_W < 1)
         $fatal(1, "LEN_W must be at least 1");
      if (BUSY_BIT < 0 || BUSY_BIT > 7)
         $fatal(1, "BUSY_BIT must index a status bit");
      if (GAP_CLKS < 0 || POLL_MAX < 0)
         $fatal(1, "GAP_CLKS and POLL_MAX must not be negative");
   end

   fbw_state_e        state;
   fbw_frame_e        frame;
   logic [IW-1:0]     idx;
   logic              final_poll;
   logic              cs_q;
   logic              err_range_q;
   logic              err_to_q;

   logic              is_data;
   logic              fixed_end;
   logic              rx_busy;
   logic              poll_reply;
   logic              closing;
   logic              gap_clear;
   logic              poll_at_limit;
   logic              poll_bump;
   logic              frame_open;
   logic [ADDR_W-1:0] trk_addr;
   logic              trk_rem_zero;
   logic              trk_trunc;
   logic              rx_unused;

   assign rx_unused = ^spi_rx;

   // ---------------- helpers ----------------
   fbw_run_tracker #(
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W),
      .TOP_ADDR(TOP_ADDR)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cmd_valid && cmd_ready),
      .addr_in   (cmd_addr),
      .len_in    (cmd_len),
      .take      (wr_valid && wr_ready),
      .start_addr(trk_addr),
      .rem_zero  (trk_rem_zero),
      .trunc     (trk_trunc)
   );

   fbw_gap_timer #(
      .GAP_CLKS(GAP_CLKS)
   ) u_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .load (closing),
      .clear(gap_clear)
   );

   fbw_poll_limit #(
      .POLL_MAX(POLL_MAX)
   ) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (frame_open),
      .bump    (poll_bump),
      .at_limit(poll_at_limit)
   );

   // ---------------- frame decode ----------------
   always_comb begin
      is_data = ((frame == FR_FIRST) && (idx == IW'(DATA_IDX))) ||
                ((frame == FR_NEXT)  && (idx == IW'(1)));
      fixed_end  = (frame == FR_WREN) || (frame == FR_WRDI) || is_data;
      rx_busy    = spi_rx[BUSY_BIT];
      poll_reply = (state == ST_WAIT) && spi_done && (frame == FR_POLL) && (idx != '0);
      closing    = (poll_reply && (!rx_busy || poll_at_limit)) ||
                   ((state == ST_WAIT) && spi_done && (frame != FR_POLL) && fixed_end);
      poll_bump  = poll_reply && rx_busy && !poll_at_limit;
      frame_open = (state == ST_OPEN) && gap_clear &&
                   !((frame == FR_WREN) && trk_rem_zero);
   end

   always_comb begin
      spi_byte = BYTE_PAD;
      unique case (frame)
         FR_WREN:  spi_byte = OP_WREN;
         FR_WRDI:  spi_byte = OP_WRDI;
         FR_POLL:  spi_byte = (idx == '0) ? OP_STAT : BYTE_PAD;
         FR_NEXT:  spi_byte = (idx == '0) ? OP_PROG : wr_data;
         FR_FIRST: begin
            if (idx == '0) begin
               spi_byte = OP_PROG;
            end else if (is_data) begin
               spi_byte = wr_data;
            end else begin
               for (int k = 1; k <= AB; k++) begin
                  if (idx == IW'(k)) spi_byte = trk_addr[ADDR_W-8*k +: 8];
               end
            end
         end
         default:  spi_byte = BYTE_PAD;
      endcase
   end

   assign cmd_ready   = (state == ST_IDLE);
   assign wr_ready    = (state == ST_ISSUE) && is_data;
   assign spi_start   = (state == ST_ISSUE) && (!is_data || wr_valid);
   assign spi_last    = (frame != FR_POLL) && fixed_end;
   assign spi_cs      = cs_q;
   assign done        = (state == ST_FINISH);
   assign err_range   = err_range_q;
   assign err_timeout = err_to_q;

   // ---------------- sequencing ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         frame       <= FR_WREN;
         idx         <= '0;
         final_poll  <= 1'b0;
         cs_q        <= 1'b0;
         err_range_q <= 1'b0;
         err_to_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  err_range_q <= 1'b0;
                  err_to_q    <= 1'b0;
                  frame       <= FR_WREN;
                  final_poll  <= 1'b0;
                  state       <= ST_OPEN;
               end
            end
            ST_OPEN: begin
               if ((frame == FR_WREN) && trk_rem_zero) begin
                  err_range_q <= trk_trunc;
                  state       <= ST_FINISH;
               end else if (gap_clear) begin
                  cs_q  <= 1'b1;
                  idx   <= '0;
                  state <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (spi_start) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (spi_done) begin
                  if (frame == FR_POLL) begin
                     if (idx == '0) begin
                        idx   <= IW'(1);
                        state <= ST_ISSUE;
                     end else if (!rx_busy) begin
                        cs_q <= 1'b0;
                        if (final_poll) begin
                           err_range_q <= trk_trunc;
                           state       <= ST_FINISH;
                        end else begin
                           frame <= trk_rem_zero ? FR_WRDI : FR_NEXT;
                           state <= ST_OPEN;
                        end
                     end else if (poll_at_limit) begin
                        cs_q        <= 1'b0;
                        err_to_q    <= 1'b1;
                        err_range_q <= trk_trunc;
                        state       <= ST_FINISH;
                     end else begin
                        state <= ST_ISSUE;
                     end
                  end else if (fixed_end) begin
                     cs_q  <= 1'b0;
                     state <= ST_OPEN;
                     unique case (frame)
                        FR_WREN: frame <= FR_FIRST;
                        FR_WRDI: begin
                           frame      <= FR_POLL;
                           final_poll <= 1'b1;
                        end
                        default: begin
                           frame      <= FR_POLL;
                           final_poll <= 1'b0;
                        end
                     endcase
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_ISSUE;
                  end
               end
            end
            ST_FINISH: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fbw_checker.sv
module fbw_checker #(
   parameter int GAP_CLKS = 4
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_ready,
   input logic wr_valid,
   input logic wr_ready,
   input logic spi_cs,
   input logic spi_start,
   input logic spi_last,
   input logic spi_done,
   input logic done,
   input logic err_range,
   input logic err_timeout
);
   localparam int DW = $clog2(GAP_CLKS + 1) + 1;

   logic          pending;
   logic [DW-1:0] desel_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending   <= 1'b0;
         desel_cnt <= DW'(GAP_CLKS);
      end else begin
         if (spi_start)     pending <= 1'b1;
         else if (spi_done) pending <= 1'b0;
         if (spi_cs)                          desel_cnt <= '0;
         else if (desel_cnt < DW'(GAP_CLKS))  desel_cnt <= desel_cnt + 1'b1;
      end
   end

   AST_START_SELECTED:  assert property (@(posedge clk) disable iff (!rst_n) spi_start |-> spi_cs); // R10
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) spi_start |-> !pending); // R10
   AST_HOLD_SELECT:     assert property (@(posedge clk) disable iff (!rst_n) pending |-> spi_cs); // R10
   AST_GAP_MIN:         assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_cs) |-> (desel_cnt >= DW'(GAP_CLKS))); // R7
   AST_DATA_HANDOFF:    assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && wr_ready) |-> (spi_start && spi_last)); // R3
   AST_DONE_RELEASED:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (!spi_cs && !pending)); // R6
   AST_DONE_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
   AST_IDLE_RELEASED:   assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> !spi_cs); // R11
   AST_TIMEOUT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_timeout) |-> done); // R9
   AST_RANGE_AT_DONE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(err_range) |-> done); // R8

endmodule

bind flash_burst_prog fbw_checker #(.GAP_CLKS(GAP_CLKS)) u_fbw_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_ready  (cmd_ready),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .spi_cs     (spi_cs),
   .spi_start  (spi_start),
   .spi_last   (spi_last),
   .spi_done   (spi_done),
   .done       (done),
   .err_range  (err_range),
   .err_timeout(err_timeout)
);

// File: tb/tb_flash_burst_prog.sv
module tb_flash_burst_prog;
   localparam int CLK_PERIOD = 10;
   localparam int TOP        = 'h00FFFF;
   localparam int GAP        = 3;
   localparam int PM         = 6;
   localparam int LAT        = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [23:0] cmd_addr = '0;
   logic [15:0] cmd_len = '0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [7:0]  wr_data = '0;
   logic        spi_cs, spi_start, spi_last;
   logic [7:0]  spi_byte;
   logic        spi_done = 1'b0;
   logic [7:0]  spi_rx = '0;
   logic        done, err_range, err_timeout;

   flash_burst_prog #(
      .ADDR_W(24), .LEN_W(16), .TOP_ADDR(24'(TOP)),
      .GAP_CLKS(GAP), .POLL_MAX(PM), .BUSY_BIT(0)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .spi_cs(spi_cs), .spi_start(spi_start), .spi_byte(spi_byte), .spi_last(spi_last),
      .spi_done(spi_done), .spi_rx(spi_rx),
      .done(done), .err_range(err_range), .err_timeout(err_timeout)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int nchecks = 0;
   int nerrs   = 0;

   logic [8:0]  exp_b[$];     // {last, byte}
   string       exp_t[$];
   logic [7:0]  data_q[$];
   int          busy_plan[$];
   int          resp_q[$];
   int          exp_frames;
   bit          exp_range, exp_to;
   int          frames_seen;
   bit          done_seen;
   bit          stall_en;
   bit          agent_on = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      nchecks++;
      if (!ok) begin
         nerrs++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   function automatic logic [7:0] dval(input int i, input int a);
      return 8'(i * 29 + a + 'h5A);
   endfunction

   task automatic push(input logic [7:0] b, input bit l, input string tag);
      exp_b.push_back({l, b});
      exp_t.push_back(tag);
   endtask

   // Expected byte stream from the requirements
   task automatic build(input int a, input int n);
      int avail, eff, p, k;
      p = 0;
      exp_b.delete(); exp_t.delete(); data_q.delete();
      exp_frames = 0; exp_to = 0;
      avail = (a > TOP) ? 0 : TOP - a + 1;
      eff = (n > avail) ? avail : n;
      exp_range = (n > avail);
      if (eff == 0) return;
      push(8'h06, 1, "R2"); exp_frames++;
      for (int i = 0; i < eff; i++) begin
         data_q.push_back(dval(i, a));
         push(8'hAF, 0, (i == 0) ? "R3" : "R4");
         if (i == 0) begin
            push(8'(a >> 16), 0, "R3");
            push(8'(a >> 8), 0, "R3");
            push(8'(a), 0, "R3");
         end
         push(dval(i, a), 1, (i == 0) ? "R3" : "R4");
         exp_frames++;
         k = (p < busy_plan.size()) ? busy_plan[p] : 0; p++;
         push(8'h05, 0, "R5");
         if (k >= PM) begin
            for (int j = 0; j < PM; j++) push(8'h00, 0, "R9");
            exp_frames++; exp_to = 1;
            return;
         end
         for (int j = 0; j <= k; j++) push(8'h00, 0, "R5");
         exp_frames++;
      end
      push(8'h04, 1, "R6"); exp_frames++;
      k = (p < busy_plan.size()) ? busy_plan[p] : 0;
      push(8'h05, 0, "R6");
      for (int j = 0; j <= k; j++) push(8'h00, 0, "R6");
      exp_frames++;
   endtask

   // Engine, flash responder, payload source, per-cycle comparison
   initial begin : agent
      int eng_cnt; bit eng_pend; logic [7:0] eng_rx;
      int fidx, low_cnt, busy_left; bit in_poll, prev_cs, pulse;
      logic [7:0] rx;
      eng_cnt = 0; eng_pend = 0; eng_rx = '0; fidx = 0; low_cnt = GAP;
      busy_left = 0; in_poll = 0; prev_cs = 0; pulse = 0;
      forever begin
         @(negedge clk);
         spi_done = 1'b0;
         if (eng_pend) begin
            if (eng_cnt == 0) begin
               spi_done = 1'b1; spi_rx = eng_rx; eng_pend = 0;
            end else eng_cnt--;
         end
         pulse = !pulse;
         wr_valid = (data_q.size() > 0) && !(stall_en && pulse);
         wr_data  = (data_q.size() > 0) ? data_q[0] : 8'h00;
         #1;
         if (!agent_on) continue;
         if (spi_cs && !prev_cs) begin
            frames_seen++;
            chk(low_cnt >= GAP, "R7", "deselect gap", low_cnt, GAP);
            fidx = 0; in_poll = 0;
         end
         if (!spi_cs) low_cnt++; else low_cnt = 0;
         prev_cs = spi_cs;
         if (spi_start) begin
            chk(spi_cs && !eng_pend, "R10", "start while selected and idle",
                {spi_cs, eng_pend}, 2'b10);
            if (exp_b.size() == 0) begin
               chk(0, "R11", "unexpected byte", spi_byte, 0);
            end else begin
               logic [8:0] e; string t;
               e = exp_b.pop_front(); t = exp_t.pop_front();
               chk(spi_byte == e[7:0], t, "byte", spi_byte, e[7:0]);
               chk(spi_last == e[8], "R12", "last flag", spi_last, e[8]);
            end
            rx = 8'hFF;
            if (fidx == 0 && spi_byte == 8'h05) begin
               in_poll = 1;
               busy_left = (resp_q.size() > 0) ? resp_q.pop_front() : 0;
               rx = 8'h01;
            end else if (in_poll) begin
               if (busy_left > 0) begin rx = 8'h01; busy_left--; end
               else rx = 8'hFE;
            end
            eng_pend = 1; eng_cnt = LAT - 1; eng_rx = rx;
            fidx++;
         end
         if (wr_valid && wr_ready) void'(data_q.pop_front());
         if (done) begin
            chk(exp_b.size() == 0, "R6", "bytes left at done", exp_b.size(), 0);
            chk(frames_seen == exp_frames, "R6", "frame count", frames_seen, exp_frames);
            chk(err_range == exp_range, "R8", "range flag", err_range, exp_range);
            chk(err_timeout == exp_to, "R9", "timeout flag", err_timeout, exp_to);
            done_seen = 1;
         end
      end
   end

   task automatic run(input int a, input int n, input bit stall, input bit poke);
      build(a, n);
      resp_q = busy_plan;
      frames_seen = 0; done_seen = 0; stall_en = stall;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R11", "idle before command", cmd_ready, 1);
      cmd_valid = 1'b1; cmd_addr = 24'(a); cmd_len = 16'(n);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (poke) begin
         repeat (8) @(negedge clk);
         chk(cmd_ready == 1'b0, "R11", "busy during run", cmd_ready, 0);
         cmd_valid = 1'b1; cmd_addr = 24'h000777; cmd_len = 16'd9;
         repeat (3) @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (!done_seen) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nerrs++; nchecks++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(spi_cs == 0 && spi_start == 0, "R1", "link idle in reset", {spi_cs, spi_start}, 0);
      chk(done == 0 && err_range == 0 && err_timeout == 0, "R1", "flags in reset",
          {done, err_range, err_timeout}, 0);
      chk(cmd_ready == 1, "R1", "ready in reset", cmd_ready, 1);
      rst_n = 1'b1;
      agent_on = 1'b1;

      busy_plan = '{2, 0};
      run('h000123, 1, 0, 0);                 // R2 R3 R5 R6
      busy_plan = '{0, 1, 3, 0, 2};
      run('h00A55A, 4, 1, 1);                 // R4 R10 R11 with stalls and poke
      busy_plan.delete();
      run('h000400, 0, 0, 0);                 // R11 zero length
      busy_plan = '{0, 0, 1};
      run('h00FFFE, 5, 0, 0);                 // R8 truncation
      busy_plan.delete();
      run('h010000, 3, 0, 0);                 // R8 start beyond top
      busy_plan = '{1, 6};
      run('h000010, 3, 0, 0);                 // R9 timeout
      busy_plan = '{5, 0, 0};
      run('h0000F0, 2, 1, 0);                 // R9 recovery, R5 long poll

      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
   end

endmodule